// File: doc/BRIEF.md
# Four-Phase Clock-Crossing Word Link

This block carries data words from a producer in one clock domain to a consumer in another, unrelated clock domain. The crossing uses a data bus and two control lines. The forward line travels with the bus and says the bus holds a valid word. The return line travels back from the consumer side. Each side brings the opposite side's control line into its own clock through a two-flop synchroniser before acting on it, and every exchange runs through all four phases. Both lines must be back at rest before the next word may start.

On the producer side the block accepts words through a valid/ready push port. On the consumer side it reports each captured word with a single-cycle output strobe. The parameter `DEST_INIT` selects the sequencing. With a value of 0 the source starts each exchange and the return line means "word taken". With a value of 1 the destination starts each exchange by raising the return line as "ready for data", and lowering that line then acknowledges the word.

Top module: `hs4_link`

## Requirements
- R1: After reset `out_valid` is 0. With `DEST_INIT`=0, `in_ready` is 1 on the first source cycle after reset. With `DEST_INIT`=1, `in_ready` stays 0 until the destination's ready line has crossed the synchroniser, so it is 0 on the first source cycle after reset.
- R2: With `DEST_INIT`=0, every word accepted on the push port (`in_valid` and `in_ready` both 1 at a rising `src_clk` edge) appears exactly once on `out_data`, in acceptance order, with `out_valid` high.
- R3: While the forward line is high, the word on the crossing bus does not change.
- R4: On the source cycle after a word is accepted, `in_ready` is 0. When the forward line falls, `in_ready` is still 0, because the return line has not yet returned to rest.
- R5: With `DEST_INIT`=1, every accepted word appears exactly once on `out_data`, in acceptance order.
- R6: `out_valid` is a pulse one `dst_clk` cycle long, and it is never high on two consecutive cycles. A pulse occurs only after the synchronised forward line was seen high.
- R7: When no word is pushed, no `out_valid` pulse occurs.
- R8: The forward line rises only when the synchronised return line is at rest. In source-initiated mode the resting level is 0. In destination-initiated mode the "at rest" condition is that the line is 1 (ready).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source-side clock |
| src_rst_n | input | 1 | Source-side asynchronous reset, active low |
| in_valid | input | 1 | Producer offers a word |
| in_ready | output | 1 | Source side can take a word this cycle |
| in_data | input | W | Word offered by the producer |
| dst_clk | input | 1 | Destination-side clock |
| dst_rst_n | input | 1 | Destination-side asynchronous reset, active low |
| out_valid | output | 1 | One-cycle strobe: a word was captured |
| out_data | output | W | Last captured word |

## Verification
The hardest situation to reach from the ports is a new push that arrives while the return line is still high from the previous exchange, or, in destination-initiated mode, before the ready line has been raised again. This is the moment at which a faulty source would overlap two words. The bench runs the source clock and the destination clock at unrelated periods (4 ns and 7 ns), so the synchroniser delays shift from word to word. It sweeps the gap between pushes from zero to several cycles, so some pushes are offered at the earliest possible cycle and must wait out the return phase. Both parameter settings get the same sweep. In addition, each word's value is computed from its index, so a lost word, a duplicated word or a torn word shows up at the destination.

// File: rtl/hs4_link.sv
module hs4_link #(
  parameter int W = 8,
  parameter int DEST_INIT = 0
) (
  input  logic         src_clk,
  input  logic         src_rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic         dst_clk,
  input  logic         dst_rst_n,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  localparam logic INV = (DEST_INIT != 0);

  logic         s_valid;
  logic [W-1:0] s_data;
  logic [1:0]   b_sync;
  logic         bp;

  logic         d_line;
  logic [1:0]   v_sync;
  logic         dp, cap, rel;

  // source domain
  assign bp       = b_sync[1] ^ INV;
  assign in_ready = !s_valid && !bp;

  always_ff @(posedge src_clk or negedge src_rst_n)
    if (!src_rst_n) b_sync <= '0;
    else            b_sync <= {b_sync[0], d_line};

  always_ff @(posedge src_clk or negedge src_rst_n)
    if (!src_rst_n) begin
      s_valid <= 1'b0;
      s_data  <= '0;
    end else if (in_valid && in_ready) begin
      s_valid <= 1'b1;
      s_data  <= in_data;
    end else if (s_valid && bp) begin
      s_valid <= 1'b0;
    end

  // destination domain
  assign dp  = d_line ^ INV;
  assign cap = v_sync[1] && !dp;
  assign rel = !v_sync[1] && dp;

  always_ff @(posedge dst_clk or negedge dst_rst_n)
    if (!dst_rst_n) v_sync <= '0;
    else            v_sync <= {v_sync[0], s_valid};

  always_ff @(posedge dst_clk or negedge dst_rst_n)
    if (!dst_rst_n) begin
      d_line    <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= cap;
      if (cap)        out_data <= s_data;
      if (cap || rel) d_line   <= ~d_line;
    end
endmodule

module hs4_link_chk #(
  parameter int W = 8
) (
  input logic         src_clk,
  input logic         src_rst_n,
  input logic         dst_clk,
  input logic         dst_rst_n,
  input logic         in_ready,
  input logic         s_valid,
  input logic [W-1:0] s_data,
  input logic         bp,
  input logic         v_s,
  input logic         out_valid
);
  a_r3_bus_stable: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    (s_valid && $past(s_valid)) |-> $stable(s_data));

  a_r4_no_ready_on_drop: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    $fell(s_valid) |-> !in_ready);

  a_r8_raise_at_rest: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    $rose(s_valid) |-> !$past(bp));

  a_r6_single_pulse: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    out_valid |=> !out_valid);

  a_r6_pulse_after_valid: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    out_valid |-> $past(v_s));
endmodule

bind hs4_link hs4_link_chk #(.W(W)) u_chk (
  .src_clk(src_clk), .src_rst_n(src_rst_n),
  .dst_clk(dst_clk), .dst_rst_n(dst_rst_n),
  .in_ready(in_ready), .s_valid(s_valid), .s_data(s_data), .bp(bp),
  .v_s(v_sync[1]), .out_valid(out_valid)
);

// File: tb/hs4_link_bench.sv
module hs4_link_bench;
  localparam int W = 8;
  localparam int N = 40;

  logic sclk = 1'b0, dclk = 1'b0;
  logic srst_n = 1'b0, drst_n = 1'b0;
  always #2   sclk = ~sclk;
  always #3.5 dclk = ~dclk;

  logic [1:0]   in_valid = '0;
  logic [W-1:0] in_data [2];
  logic [1:0]   in_ready, out_valid;
  logic [W-1:0] out_data [2];

  int checks = 0, fails = 0;
  int rcv [2];
  logic [1:0] prev_ov = '0;
  bit done = 0;

  initial begin
    in_data[0] = '0; in_data[1] = '0;
    rcv[0] = 0; rcv[1] = 0;
  end

  hs4_link #(.W(W), .DEST_INIT(0)) u_hs4_link (
    .src_clk(sclk), .src_rst_n(srst_n), .in_valid(in_valid[0]), .in_ready(in_ready[0]),
    .in_data(in_data[0]), .dst_clk(dclk), .dst_rst_n(drst_n),
    .out_valid(out_valid[0]), .out_data(out_data[0]));

  hs4_link #(.W(W), .DEST_INIT(1)) u_hs4_link_di (
    .src_clk(sclk), .src_rst_n(srst_n), .in_valid(in_valid[1]), .in_ready(in_ready[1]),
    .in_data(in_data[1]), .dst_clk(dclk), .dst_rst_n(drst_n),
    .out_valid(out_valid[1]), .out_data(out_data[1]));

  function automatic logic [W-1:0] word(int i, int m);
    return W'((i * 37 + m * 91 + 5) & 255);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge dclk) begin
    if (drst_n) begin
      for (int m = 0; m < 2; m++) begin
        if (out_valid[m]) begin
          check(out_data[m] == word(rcv[m], m), m == 0 ? "R2 R3 data" : "R5 R3 data",
                int'(out_data[m]), int'(word(rcv[m], m)));
          check(!prev_ov[m], "R6 pulse width", int'(prev_ov[m]), 0);
          rcv[m]++;
        end
        prev_ov[m] = out_valid[m];
      end
    end
  end

  task automatic push(int m, int i);
    @(negedge sclk);
    in_valid[m] = 1'b1;
    in_data[m]  = word(i, m);
    while (!in_ready[m]) @(negedge sclk);
    @(posedge sclk);
    @(negedge sclk);
    in_valid[m] = 1'b0;
    in_data[m]  = ~in_data[m];
    check(!in_ready[m], "R4 ready after accept", int'(in_ready[m]), 0);
  endtask

  initial begin
    repeat (5) @(negedge sclk);
    check(out_valid == 2'b00, "R1 reset out_valid", int'(out_valid), 0);
    @(negedge sclk);
    srst_n = 1'b1; drst_n = 1'b1;
    @(negedge sclk);
    check(in_ready[0] == 1'b1, "R1 src-init ready", int'(in_ready[0]), 1);
    check(in_ready[1] == 1'b0, "R1 R8 dst-init not ready", int'(in_ready[1]), 0);
    check(out_valid == 2'b00, "R1 out_valid after reset", int'(out_valid), 0);

    for (int m = 0; m < 2; m++) begin
      repeat (30) @(negedge sclk);
      check(rcv[m] == 0, "R7 idle no output", rcv[m], 0);
      for (int i = 0; i < N; i++) begin
        push(m, i);
        repeat (i % 5) @(negedge sclk);
      end
      for (int t = 0; t < 200 && rcv[m] < N; t++) @(negedge sclk);
      check(rcv[m] == N, m == 0 ? "R2 word count" : "R5 word count", rcv[m], N);
    end

    repeat (60) @(negedge dclk);
    check(rcv[0] == N, "R7 no extra output", rcv[0], N);
    check(rcv[1] == N, "R7 no extra output", rcv[1], N);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #600000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", rcv[0] + rcv[1], 2 * N);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule